// File: doc/BRIEF.md
# Serial Peripheral Port with Status Flags

This block is an 8-bit serial peripheral port. It runs as either bus master or bus slave and sits on a simple four-register bus. The four registers are a control register, a rate register, a read-only status register and a data register. Writing the data register while the block is master shifts a byte out and a byte in over eight SCK cycles, in mode 0 and MSB first. In slave mode the same write preloads the byte that the remote master will clock out. The status register holds three flags: transfer done, write collision and mode fault. Each flag clears only through a two-step access sequence.

The block also produces the output enables for its four pins. Per-pin direction bits and a slave-select output enable decide which pins it drives. A single-wire mode reroutes the data input: the master uses its MOSI pin for both directions and the slave uses its MISO pin. Pad cells and interrupt routing stay outside the block.

Register addresses: 0 control, 1 rate, 2 status, 3 data. Control bits: bit 4 master, bit 1 SS output enable, bit 0 single-wire mode. Direction input bits: [0] MISO, [1] MOSI, [2] SCK, [3] SS.

Top module: `spi_port`

## Requirements
- R1: The rate register resets to 0 and is readable and writable at any time. Its 3-bit value sel sets the SCK period to 2^(sel+1) system clocks, so SCK first rises 2^sel cycles after the data write edge.
- R2: In master mode, a data write while idle starts eight SCK cycles. The MSB is on MOSI at once and SCK idles low. The byte shifted in is read back from the data register.
- R3: The done flag (status bit 7) sets at the end of the eighth SCK cycle, one clock after the last falling SCK. It clears only after a status read that sees it set, followed by a data-register read or write. A data access without that earlier read leaves it set.
- R4: A data write during a transfer is dropped and the byte in flight is unchanged. The write sets the collision flag (status bit 6), which clears through the same read-status-then-access-data sequence.
- R5: The status register ignores writes. Bits 5 and 3..0 read zero, and it resets to 0x00.
- R6: If SS is low while the block is master and its SS output is not enabled, the mode-fault flag (status bit 4) sets 3 cycles later and the master control bit drops to 0. The flag clears after a status read that sees it set, followed by a control-register write.
- R7: SCK is driven only when its direction bit is 1 and the block is master. SS is driven only when its direction bit is 1, the SS output enable bit is 1 and the block is master. MOSI is driven only when its direction bit is 1 and the block is master. MISO is driven only when its direction bit is 1, SS is low and the block is slave.
- R8: In single-wire mode the master samples its data from the MOSI pin instead of MISO.
- R9: In slave mode, SCK, SS and the data input pass through two flops each. SCK edges are ignored while SS is high. Bytes move MSB first in mode 0 and the done flag sets after the eighth falling SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| dir_i | input | 4 | Pin direction bits: MISO, MOSI, SCK, SS |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output |
| sck_oe_o | output | 1 | SCK output enable |
| ss_ni | input | 1 | SS pin input, active low |
| ss_no | output | 1 | SS pin output, low during master transfer |
| ss_oe_o | output | 1 | SS output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe_o | output | 1 | MISO output enable |

## Verification
Register reads and output enables are combinational, so they are checked in the same cycle a few nanoseconds after the falling edge. In master mode the first SCK rise is due 2^sel clocks after the write edge and the done flag 16·2^sel+1 clocks after it. The bench counts exactly that many falling edges and checks for a 0 one cycle before the result is due and for a 1 on the cycle it is due. The mode-fault flag is checked 2 and 3 cycles after SS falls. Slave results pass through the synchroniser, so they are checked with several idle clocks of margin after the last SCK edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_RATE = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_addr_e;

  localparam int STAT_DONE = 7;
  localparam int STAT_WCOL = 6;
  localparam int STAT_MODF = 4;
  localparam int CTRL_MSTR = 4;
  localparam int CTRL_SSOE = 1;
  localparam int CTRL_BIDI = 0;

  localparam int DIR_MISO = 0;
  localparam int DIR_MOSI = 1;
  localparam int DIR_SCK  = 2;
  localparam int DIR_SS   = 3;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim;

  // half SCK period is 2^sel system clocks
  assign lim    = ({{CNT_W{1'b0}}, 1'b1} << sel_i) - {{CNT_W{1'b0}}, 1'b1};
  assign tick_o = run_i && ({1'b0, cnt_q} == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          sel_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          din_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          sck_o,
  output logic          dout_o,
  output logic [DW-1:0] rx_o
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          samp_q;

  assign dout_o = sh_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      samp_q <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sck_o  <= 1'b0;
      rx_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        sh_q   <= wdata_i;
        cnt_q  <= '0;
        sck_o  <= 1'b0;
        busy_o <= master_i;
      end else if (master_i) begin
        if (busy_o && tick_i) begin
          if (!sck_o) begin
            sck_o  <= 1'b1;
            samp_q <= din_i;
          end else begin
            sck_o <= 1'b0;
            sh_q  <= {sh_q[DW-2:0], samp_q};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
              rx_o   <= {sh_q[DW-2:0], samp_q};
            end
          end
        end
      end else begin
        sck_o <= 1'b0;
        if (!sel_i) begin
          cnt_q  <= '0;
          busy_o <= 1'b0;
        end else if (rise_i) begin
          samp_q <= din_i;
          busy_o <= 1'b1;
        end else if (fall_i && busy_o) begin
          sh_q  <= {sh_q[DW-2:0], samp_q};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            rx_o   <= {sh_q[DW-2:0], samp_q};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [3:0]    dir_i,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          ss_ni,
  output logic          ss_no,
  output logic          ss_oe_o,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe_o
);
  logic             master_q, ssoe_q, bidi_q;
  logic [SEL_W-1:0] rate_q;
  logic             spif, wcol, modf;
  logic             spif_arm, wcol_arm, modf_arm;
  logic             busy, done, tick, sck_int, dout;
  logic [DW-1:0]    rx;
  logic [2:0]       sync_d, sync_q;
  logic             ss_s, sck_s, din_s, sck_d;
  logic             stat_rd, data_acc, data_wr, ctrl_wr, modf_hit, load;

  assign stat_rd  = rd_i && (reg_addr_e'(addr_i) == REG_STAT);
  assign data_acc = (rd_i || wr_i) && (reg_addr_e'(addr_i) == REG_DATA);
  assign data_wr  = wr_i && (reg_addr_e'(addr_i) == REG_DATA);
  assign ctrl_wr  = wr_i && (reg_addr_e'(addr_i) == REG_CTRL);
  assign load     = data_wr && !busy;

  // slave-side inputs; the data pin depends on single-wire mode
  assign sync_d = {ss_ni, sck_i, bidi_q ? miso_i : mosi_i};
  spi_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sync_d), .q_o(sync_q)
  );
  assign {ss_s, sck_s, din_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  assign modf_hit = master_q && !(dir_i[DIR_SS] && ssoe_q) && !ss_s;

  spi_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(busy && master_q),
    .sel_i (rate_q), .tick_o(tick)
  );

  spi_shift #(.DW(DW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(master_q),
    .load_i  (load),
    .wdata_i (wdata_i),
    .tick_i  (tick),
    .sel_i   (!ss_s),
    .rise_i  (sck_s && !sck_d),
    .fall_i  (!sck_s && sck_d),
    .din_i   (master_q ? (bidi_q ? mosi_i : miso_i) : din_s),
    .busy_o  (busy),
    .done_o  (done),
    .sck_o   (sck_int),
    .dout_o  (dout),
    .rx_o    (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      ssoe_q   <= 1'b0;
      bidi_q   <= 1'b0;
      rate_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        master_q <= wdata_i[CTRL_MSTR];
        ssoe_q   <= wdata_i[CTRL_SSOE];
        bidi_q   <= wdata_i[CTRL_BIDI];
      end
      if (modf_hit) master_q <= 1'b0;
      if (wr_i && (reg_addr_e'(addr_i) == REG_RATE)) rate_q <= wdata_i[SEL_W-1:0];
    end
  end

  // two-step clears; a new set wins and disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {spif, wcol, modf}             <= '0;
      {spif_arm, wcol_arm, modf_arm} <= '0;
    end else begin
      if (stat_rd && spif) spif_arm <= 1'b1;
      if (stat_rd && wcol) wcol_arm <= 1'b1;
      if (stat_rd && modf) modf_arm <= 1'b1;
      if (data_acc && spif_arm) begin spif <= 1'b0; spif_arm <= 1'b0; end
      if (data_acc && wcol_arm) begin wcol <= 1'b0; wcol_arm <= 1'b0; end
      if (ctrl_wr && modf_arm)  begin modf <= 1'b0; modf_arm <= 1'b0; end
      if (done)              begin spif <= 1'b1; spif_arm <= 1'b0; end
      if (data_wr && busy)   begin wcol <= 1'b1; wcol_arm <= 1'b0; end
      if (modf_hit)          begin modf <= 1'b1; modf_arm <= 1'b0; end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      REG_CTRL: begin
        rdata_o[CTRL_MSTR] = master_q;
        rdata_o[CTRL_SSOE] = ssoe_q;
        rdata_o[CTRL_BIDI] = bidi_q;
      end
      REG_RATE: rdata_o[SEL_W-1:0] = rate_q;
      REG_STAT: begin
        rdata_o[STAT_DONE] = spif;
        rdata_o[STAT_WCOL] = wcol;
        rdata_o[STAT_MODF] = modf;
      end
      REG_DATA: rdata_o = rx;
      default:  rdata_o = '0;
    endcase
  end

  assign sck_o     = sck_int;
  assign mosi_o    = dout;
  assign miso_o    = dout;
  assign ss_no     = !busy;
  assign sck_oe_o  = dir_i[DIR_SCK] && master_q;
  assign ss_oe_o   = dir_i[DIR_SS] && ssoe_q && master_q;
  assign mosi_oe_o = dir_i[DIR_MOSI] && master_q;
  assign miso_oe_o = dir_i[DIR_MISO] && !ss_ni && !master_q;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic [3:0] dir_i,
  input logic       ss_ni,
  input logic       sck_o,
  input logic       sck_oe_o,
  input logic       ss_oe_o,
  input logic       mosi_oe_o,
  input logic       miso_oe_o,
  input logic       busy,
  input logic       spif,
  input logic       wcol
);
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o); // R2
  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3 && busy) |=> wcol); // R4
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spif && !((rd_i || wr_i) && addr_i == 2'd3)) |=> spif); // R3
  AST_STAT_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd2) |-> (rdata_o[5] == 1'b0 && rdata_o[3:0] == 4'd0)); // R5
  AST_SCK_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_oe_o |-> dir_i[2]); // R7
  AST_SS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_oe_o |-> dir_i[3]); // R7
  AST_MISO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> (!ss_ni && dir_i[0] && !mosi_oe_o)); // R7
endmodule

bind spi_port spi_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .dir_i    (dir_i),
  .ss_ni    (ss_ni),
  .sck_o    (sck_o),
  .sck_oe_o (sck_oe_o),
  .ss_oe_o  (ss_oe_o),
  .mosi_oe_o(mosi_oe_o),
  .miso_oe_o(miso_oe_o),
  .busy     (busy),
  .spif     (spif),
  .wcol     (wcol)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'd0, rdata;
  logic [3:0] dir = 4'hF;
  logic       sck_in = 1'b0, ss_n = 1'b1;
  logic       sck_o, sck_oe, ss_no, ss_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       slv = 1'b0, lb_bidir = 1'b0, tb_mosi = 1'b0;
  logic       miso_w, mosi_w;
  int         errors = 0, checks = 0;

  always #10 clk = ~clk;

  assign miso_w = slv ? 1'b0 : (lb_bidir ? 1'b0 : mosi_o);
  assign mosi_w = slv ? tb_mosi : (lb_bidir ? mosi_o : 1'b0);

  spi_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .dir_i(dir),
    .sck_i(sck_in), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .ss_ni(ss_n), .ss_no(ss_no), .ss_oe_o(ss_oe),
    .mosi_i(mosi_w), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_i(miso_w), .miso_o(miso_o), .miso_oe_o(miso_oe)
  );

  // {sel, tx}
  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'hA5}, {3'd1, 8'h3C}, {3'd2, 8'h81},
    {3'd3, 8'h7E}, {3'd7, 8'h01}, {3'd0, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // reset state
    peek(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    peek(2'd1, v); chk("R1 rate reset", v, 8'h00);
    peek(2'd2, v); chk("R5 stat reset", v, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2'd1, v); chk("R1 rate after reset", v, 8'h00);
    chk("R7 oe at reset", {4'd0, sck_oe, ss_oe, mosi_oe, miso_oe}, 8'h00);
    bus_wr(2'd1, 8'h05); peek(2'd1, v); chk("R1 rate rw", v, 8'h05);
    bus_wr(2'd2, 8'hFF); peek(2'd2, v); chk("R5 stat write ignored", v, 8'h00);

    // master transfers, normal-mode loopback
    bus_wr(2'd0, 8'h12);
    for (int i = 0; i < 6; i++) begin
      int h;
      logic [2:0] sel;
      logic [7:0] tx;
      {sel, tx} = VEC[i];
      h = 1 << sel;
      bus_wr(2'd1, {5'd0, sel});
      bus_wr(2'd3, tx);
      chk("R2 msb first", {7'd0, mosi_o}, {7'd0, tx[7]});
      chk("R2 ss low", {7'd0, ss_no}, 8'h00);
      repeat (h - 1) @(negedge clk);
      chk("R1 sck low before 2^sel", {7'd0, sck_o}, 8'h00);
      @(negedge clk);
      chk("R1 sck high at 2^sel", {7'd0, sck_o}, 8'h01);
      repeat (15 * h) @(negedge clk);
      peek(2'd2, v); chk("R3 done not yet", v, 8'h00);
      @(negedge clk);
      peek(2'd2, v); chk("R3 done set", v, 8'h80);
      chk("R2 sck idle", {7'd0, sck_o}, 8'h00);
      bus_rd(2'd2, v);
      bus_rd(2'd3, v); chk("R2 rx loopback", v, tx);
      peek(2'd2, v); chk("R3 done cleared", v, 8'h00);
    end

    // data access without status read keeps done; status write ignored
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd3, 8'h5A);
    repeat (20) @(negedge clk);
    bus_rd(2'd3, v); chk("R2 rx", v, 8'h5A);
    peek(2'd2, v); chk("R3 access alone no clear", v, 8'h80);
    bus_wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R5 stat write no effect", v, 8'h80);
    bus_rd(2'd2, v); bus_wr(2'd3, 8'h00);
    repeat (20) @(negedge clk);
    bus_rd(2'd2, v); bus_rd(2'd3, v);

    // write collision
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd3, 8'hC3);
    repeat (3) @(negedge clk);
    bus_wr(2'd3, 8'h18);
    peek(2'd2, v); chk("R4 wcol set", v, 8'h40);
    repeat (40) @(negedge clk);
    peek(2'd2, v); chk("R4 both flags", v, 8'hC0);
    bus_rd(2'd2, v);
    bus_rd(2'd3, v); chk("R4 byte not corrupted", v, 8'hC3);
    peek(2'd2, v); chk("R4 wcol cleared", v, 8'h00);

    // single-wire master
    lb_bidir = 1'b1;
    bus_wr(2'd0, 8'h13);
    chk("R7 bidir master oe", {6'd0, mosi_oe, miso_oe}, 8'h02);
    bus_wr(2'd3, 8'h6D);
    repeat (40) @(negedge clk);
    bus_rd(2'd2, v);
    bus_rd(2'd3, v); chk("R8 rx via mosi pin", v, 8'h6D);
    lb_bidir = 1'b0;

    // output enables
    bus_wr(2'd0, 8'h12);
    chk("R7 master enables", {4'd0, sck_oe, ss_oe, mosi_oe, miso_oe}, 8'h0E);
    dir = 4'b1011;
    @(negedge clk);
    chk("R7 sck dir off", {7'd0, sck_oe}, 8'h00);
    dir = 4'hF;
    bus_wr(2'd0, 8'h10);
    chk("R7 ssoe off", {7'd0, ss_oe}, 8'h00);

    // mode fault
    @(negedge clk); ss_n = 1'b0;
    repeat (2) @(negedge clk);
    peek(2'd2, v); chk("R6 modf not yet", v, 8'h00);
    @(negedge clk);
    peek(2'd2, v); chk("R6 modf set", v, 8'h10);
    peek(2'd0, v); chk("R6 master dropped", v, 8'h00);
    ss_n = 1'b1;
    bus_wr(2'd0, 8'h00);
    peek(2'd2, v); chk("R6 no clear without read", v, 8'h10);
    bus_rd(2'd2, v); bus_wr(2'd0, 8'h00);
    peek(2'd2, v); chk("R6 modf cleared", v, 8'h00);

    // slave
    slv = 1'b1;
    bus_wr(2'd3, 8'h96);
    repeat (3) begin
      tb_mosi = 1'b1;
      repeat (6) @(negedge clk); sck_in = 1'b1;
      repeat (6) @(negedge clk); sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    peek(2'd2, v); chk("R9 sck ignored while ss high", v, 8'h00);
    chk("R7 slave miso off ss high", {7'd0, miso_oe}, 8'h00);
    ss_n = 1'b0;
    @(negedge clk);
    chk("R7 slave miso on", {7'd0, miso_oe}, 8'h01);
    begin
      logic [7:0] got = 8'd0;
      logic [7:0] sent = 8'h5A;
      for (int b = 7; b >= 0; b--) begin
        tb_mosi = sent[b];
        repeat (6) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_in = 1'b1;
        repeat (6) @(negedge clk);
        sck_in = 1'b0;
      end
      repeat (6) @(negedge clk);
      chk("R9 slave tx msb first", got, 8'h96);
      peek(2'd2, v); chk("R9 slave done", v, 8'h80);
      bus_rd(2'd2, v);
      bus_rd(2'd3, v); chk("R9 slave rx", v, sent);
    end
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule